// File: doc/BRIEF.md
# Guard-Bit Multiply-Accumulate Unit

This block is a two-stage multiply-accumulate datapath. On every clock it can take one pair of signed operands, form their full-precision signed product, and either load that product into a wide accumulator or add it to the running total. The accumulator is wider than the product by a set of guard bits, so long dot products can run without losing headroom. With the default parameters, the operands are 16 bits, the product is 32 bits and the accumulator is 40 bits.

The caller raises `in_vld` for each operand pair. Raising `acc_clr` with an operand pair starts a new sum: that product replaces the total, so back-to-back dot products need no idle cycle. The `sat_mode` input selects one of two behaviours when the 40-bit range is exceeded. In saturate mode the total clamps at the range limit. In wrap mode it rolls over. In both modes a sticky flag records that the range was exceeded.

The total is presented as a low word and a high guard word, the way a register pair would hold it. A second output gives the total clamped to the 32-bit signed range, ready to be read as a single word.

Top module: `guard_mac`

## Requirements
- R1: When `in_vld` and `acc_clr` are both high, the accumulator is loaded with the exact signed product `op_a*op_b`, sign-extended to 40 bits, and `ovf_flag` is cleared. This includes -32768 times -32768, which gives +2^30.
- R2: When `in_vld` is high and `acc_clr` is low, the signed product is added to the accumulator.
- R3: The effect of an operand pair sampled at rising edge k is visible on the outputs after rising edge k+1. A new pair can be accepted on every edge, with no idle cycles.
- R4: When `in_vld` is low, the accumulator and `ovf_flag` hold their values, whatever is driven on `op_a`, `op_b`, `acc_clr` and `sat_mode`.
- R5: With `sat_mode` high (saturate), a sum above 2^39-1 becomes 2^39-1, and a sum below -2^39 becomes -2^39.
- R6: With `sat_mode` low (wrap), the sum is kept modulo 2^40 as a two's-complement value.
- R7: `ovf_flag` goes high when the exact sum of an add leaves the 40-bit signed range, in either mode. It stays high until a load (R1) or a reset.
- R8: `acc_lo` carries accumulator bits 31..0 and `acc_hi` carries bits 39..32.
- R9: `res32` equals the accumulator when the accumulator lies within [-2^31, 2^31-1]. Otherwise it is 2^31-1 for a positive accumulator and -2^31 for a negative one.
- R10: A synchronous, active-high `rst` sets the accumulator and `ovf_flag` to zero and discards any operand pair still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand pair valid; enables a load or an add |
| acc_clr | input | 1 | Load the product instead of adding it |
| sat_mode | input | 1 | 1 = saturate at the 40-bit limits, 0 = wrap |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier |
| acc_lo | output | 32 | Accumulator bits 31..0 |
| acc_hi | output | 8 | Accumulator guard bits 39..32 |
| res32 | output | 32 | Accumulator clamped to the 32-bit signed range |
| ovf_flag | output | 1 | Sticky flag: the 40-bit range was exceeded |

## Verification
The accumulator is the only long-lived state, so an error in it cannot heal itself. A bad product register or a bad carry into the accumulator corrupts `acc_lo`/`acc_hi` on the second edge after the operand pair. That error then persists in every later partial sum until the next load. A mis-detected overflow shows up on `ovf_flag` at the same edge and then sticks. A broken clamp is visible only on the edge where the exact sum first crosses a 40-bit limit, so the bench drives runs of maximum-magnitude products across both limits in both modes.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int MAC_OP_W  = 16;
    localparam int MAC_GUARD = 8;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_LOAD = 2'd1,
        OP_ADD  = 2'd2
    } acc_op_e;

    typedef enum logic {
        MODE_WRAP = 1'b0,
        MODE_SAT  = 1'b1
    } sat_mode_e;

    function automatic acc_op_e decode_op(input logic vld, input logic clr);
        if (!vld)
            return OP_IDLE;
        else if (clr)
            return OP_LOAD;
        else
            return OP_ADD;
    endfunction

    function automatic sat_mode_e decode_mode(input logic sat);
        return sat ? MODE_SAT : MODE_WRAP;
    endfunction

endpackage

// File: rtl/mac_mul_stage.sv
module mac_mul_stage
    import mac_pkg::*;
#(
    parameter int OP_W = MAC_OP_W,
    localparam int PROD_W = 2 * OP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic              acc_clr,
    input  logic              sat_mode,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output acc_op_e           s1_op,
    output sat_mode_e         s1_mode,
    output logic [PROD_W-1:0] s1_prod
);

    typedef struct packed {
        acc_op_e           op;
        sat_mode_e         mode;
        logic [PROD_W-1:0] prod;
    } mul_stage_t;

    mul_stage_t        nxt;
    mul_stage_t        cur;
    logic [PROD_W-1:0] a_ext;
    logic [PROD_W-1:0] b_ext;

    // Sign-extend both operands to the product width. The truncated
    // product is then the exact signed result.
    always_comb begin
        a_ext    = {{OP_W{op_a[OP_W-1]}}, op_a};
        b_ext    = {{OP_W{op_b[OP_W-1]}}, op_b};
        nxt.op   = decode_op(in_vld, acc_clr);
        nxt.mode = decode_mode(sat_mode);
        nxt.prod = a_ext * b_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.op   <= OP_IDLE;
            cur.mode <= MODE_WRAP;
            cur.prod <= '0;
        end else begin
            cur.op   <= nxt.op;
            cur.mode <= nxt.mode;
            if (in_vld)
                cur.prod <= nxt.prod;
        end
    end

    assign s1_op   = cur.op;
    assign s1_mode = cur.mode;
    assign s1_prod = cur.prod;

endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
    import mac_pkg::*;
#(
    parameter int PROD_W = 2 * MAC_OP_W,
    parameter int GUARD  = MAC_GUARD,
    localparam int ACC_W = PROD_W + GUARD
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_op_e           s1_op,
    input  sat_mode_e         s1_mode,
    input  logic [PROD_W-1:0] s1_prod,
    output logic [ACC_W-1:0]  acc_q,
    output logic              ovf_q
);

    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W:0]   sum_ext;
    logic             range_exc;
    logic [ACC_W-1:0] add_res;

    // One extra bit holds the exact sum. The range is exceeded when its
    // top two bits disagree.
    always_comb begin
        prod_ext  = {{GUARD{s1_prod[PROD_W-1]}}, s1_prod};
        sum_ext   = {acc_q[ACC_W-1], acc_q} + {prod_ext[ACC_W-1], prod_ext};
        range_exc = sum_ext[ACC_W] ^ sum_ext[ACC_W-1];
        if (range_exc && s1_mode == MODE_SAT)
            add_res = sum_ext[ACC_W] ? ACC_MIN : ACC_MAX;
        else
            add_res = sum_ext[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            unique case (s1_op)
                OP_LOAD: begin
                    acc_q <= prod_ext;
                    ovf_q <= 1'b0;
                end
                OP_ADD: begin
                    acc_q <= add_res;
                    ovf_q <= ovf_q | range_exc;
                end
                default: begin
                    acc_q <= acc_q;
                    ovf_q <= ovf_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/mac_narrow_sat.sv
module mac_narrow_sat #(
    parameter int IN_W  = 40,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  wide,
    output logic [OUT_W-1:0] narrow
);

    localparam logic [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] OUT_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    generate
        if (IN_W <= OUT_W) begin : g_pass
            assign narrow = OUT_W'($signed(wide));
        end else begin : g_clamp
            logic [IN_W-OUT_W:0] top;
            logic                fits;
            // The value fits when the dropped bits and the new sign bit
            // are all copies of one another.
            always_comb begin
                top  = wide[IN_W-1:OUT_W-1];
                fits = (&top) | ~(|top);
                if (fits)
                    narrow = wide[OUT_W-1:0];
                else
                    narrow = wide[IN_W-1] ? OUT_MIN : OUT_MAX;
            end
        end
    endgenerate

endmodule

// File: rtl/guard_mac.sv
module guard_mac
    import mac_pkg::*;
#(
    parameter int OP_W  = MAC_OP_W,
    parameter int GUARD = MAC_GUARD,
    localparam int PROD_W = 2 * OP_W,
    localparam int ACC_W  = PROD_W + GUARD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic              acc_clr,
    input  logic              sat_mode,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [PROD_W-1:0] acc_lo,
    output logic [GUARD-1:0]  acc_hi,
    output logic [PROD_W-1:0] res32,
    output logic              ovf_flag
);

    acc_op_e           s1_op;
    sat_mode_e         s1_mode;
    logic [PROD_W-1:0] s1_prod;
    logic [ACC_W-1:0]  acc_q;
    logic              ovf_q;

    mac_mul_stage #(.OP_W(OP_W)) u_mul (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_vld),
        .acc_clr  (acc_clr),
        .sat_mode (sat_mode),
        .op_a     (op_a),
        .op_b     (op_b),
        .s1_op    (s1_op),
        .s1_mode  (s1_mode),
        .s1_prod  (s1_prod)
    );

    mac_acc_stage #(.PROD_W(PROD_W), .GUARD(GUARD)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .s1_op   (s1_op),
        .s1_mode (s1_mode),
        .s1_prod (s1_prod),
        .acc_q   (acc_q),
        .ovf_q   (ovf_q)
    );

    mac_narrow_sat #(.IN_W(ACC_W), .OUT_W(PROD_W)) u_sat32 (
        .wide   (acc_q),
        .narrow (res32)
    );

    assign acc_lo   = acc_q[PROD_W-1:0];
    assign acc_hi   = acc_q[ACC_W-1:PROD_W];
    assign ovf_flag = ovf_q;

endmodule

// File: rtl/guard_mac_chk.sv
module guard_mac_chk #(
    parameter int OP_W  = 16,
    parameter int GUARD = 8,
    localparam int PROD_W = 2 * OP_W,
    localparam int ACC_W  = PROD_W + GUARD
) (
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic              acc_clr,
    input logic [OP_W-1:0]   op_a,
    input logic [OP_W-1:0]   op_b,
    input logic [PROD_W-1:0] acc_lo,
    input logic [GUARD-1:0]  acc_hi,
    input logic [PROD_W-1:0] res32,
    input logic              ovf_flag
);

    localparam logic [PROD_W-1:0] W_MAX = {1'b0, {(PROD_W-1){1'b1}}};
    localparam logic [PROD_W-1:0] W_MIN = {1'b1, {(PROD_W-1){1'b0}}};

    logic [1:0]        cyc;
    logic              v1, v2, c1, c2;
    logic [OP_W-1:0]   a1, a2, b1, b2;
    logic [ACC_W-1:0]  acc_full;
    logic [ACC_W-1:0]  prod_ref;
    logic [PROD_W-OP_W-1:0] unused_pad;
    logic              fits32;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc <= '0;
            v1  <= 1'b0;
            v2  <= 1'b0;
            c1  <= 1'b0;
            c2  <= 1'b0;
        end else begin
            if (cyc != 2'd3)
                cyc <= cyc + 2'd1;
            v1 <= in_vld;
            v2 <= v1;
            c1 <= acc_clr;
            c2 <= c1;
        end
        a1 <= op_a;
        a2 <= a1;
        b1 <= op_b;
        b2 <= b1;
    end

    always_comb begin
        acc_full = {acc_hi, acc_lo};
        prod_ref = ACC_W'($signed(a2) * $signed(b2));
        unused_pad = '0;
        fits32   = (&acc_full[ACC_W-1:PROD_W-1]) | ~(|acc_full[ACC_W-1:PROD_W-1]);
    end

    AST_LOAD_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2 && v2 && c2) |-> (acc_full == prod_ref && !ovf_flag)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2 && !v2) |-> ($stable(acc_full) && $stable(ovf_flag))); // R4

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2 && $past(ovf_flag) && !(v2 && c2)) |-> ovf_flag); // R7

    AST_RES_PASS: assert property (@(posedge clk) disable iff (rst)
        fits32 |-> (res32 == acc_lo)); // R9

    AST_RES_CLAMP: assert property (@(posedge clk) disable iff (rst)
        !fits32 |-> (res32 == (acc_hi[GUARD-1] ? W_MIN : W_MAX))); // R9

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd0) |-> (acc_full == '0 && !ovf_flag)); // R10

endmodule

bind guard_mac guard_mac_chk #(.OP_W(OP_W), .GUARD(GUARD)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .acc_clr  (acc_clr),
    .op_a     (op_a),
    .op_b     (op_b),
    .acc_lo   (acc_lo),
    .acc_hi   (acc_hi),
    .res32    (res32),
    .ovf_flag (ovf_flag)
);

// File: tb/guard_mac_test.sv
module guard_mac_test;

    localparam longint ACC_MAX = (64'sd1 <<< 39) - 1;
    localparam longint ACC_MIN = -(64'sd1 <<< 39);
    localparam longint W_MAX   = (64'sd1 <<< 31) - 1;
    localparam longint W_MIN   = -(64'sd1 <<< 31);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic        acc_clr = 1'b0;
    logic        sat_mode = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [31:0] acc_lo;
    logic [7:0]  acc_hi;
    logic [31:0] res32;
    logic        ovf_flag;

    int checks = 0;
    int fails  = 0;

    longint m_acc = 0;
    bit     m_ovf = 1'b0;
    longint e1_acc = 0, e2_acc = 0;
    bit     e1_ovf = 1'b0, e2_ovf = 1'b0;

    always #5 clk = ~clk;

    guard_mac uut (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_vld),
        .acc_clr  (acc_clr),
        .sat_mode (sat_mode),
        .op_a     (op_a),
        .op_b     (op_b),
        .acc_lo   (acc_lo),
        .acc_hi   (acc_hi),
        .res32    (res32),
        .ovf_flag (ovf_flag)
    );

    function automatic longint grid(input int i);
        case (i)
            0: return -32768;   1: return -32767;  2: return -256;
            3: return -3;       4: return -1;      5: return 0;
            6: return 1;        7: return 2;       8: return 255;
            9: return 12345;   10: return 32766;  default: return 32767;
        endcase
    endfunction

    function automatic longint clamp32(input longint v);
        if (v > W_MAX) return W_MAX;
        if (v < W_MIN) return W_MIN;
        return v;
    endfunction

    task automatic compare_outputs(input string tag);
        logic signed [39:0] got;
        longint             got_res;
        got = {acc_hi, acc_lo};
        checks++;
        if (longint'(got) != e2_acc) begin
            fails++;
            $display("FAIL %s R8 acc: got %0d expected %0d", tag, got, e2_acc);
        end
        checks++;
        got_res = longint'($signed(res32));
        if (got_res != clamp32(e2_acc)) begin
            fails++;
            $display("FAIL R9 res32: got %0d expected %0d", got_res, clamp32(e2_acc));
        end
        checks++;
        if (ovf_flag != e2_ovf) begin
            fails++;
            $display("FAIL %s R7 ovf_flag: got %0b expected %0b", tag, ovf_flag, e2_ovf);
        end
    endtask

    // One clock: check what the pair from two edges ago produced, then
    // drive the next pair and advance the model.
    task automatic step(input bit r, input bit v, input bit c, input bit s,
                        input longint a, input longint b, input string tag);
        longint             p, sum;
        logic signed [39:0] wrapped;
        @(negedge clk);
        compare_outputs(tag);
        rst      = r;
        in_vld   = v;
        acc_clr  = c;
        sat_mode = s;
        op_a     = a[15:0];
        op_b     = b[15:0];
        e2_acc = e1_acc;
        e2_ovf = e1_ovf;
        if (r) begin
            m_acc = 0; m_ovf = 1'b0;
            e2_acc = 0; e2_ovf = 1'b0;
        end else if (v) begin
            p = a * b;
            if (c) begin
                m_acc = p; m_ovf = 1'b0;
            end else begin
                sum = m_acc + p;
                if (sum > ACC_MAX || sum < ACC_MIN) begin
                    m_ovf = 1'b1;
                    if (s) begin
                        sum = (sum > ACC_MAX) ? ACC_MAX : ACC_MIN;
                    end else begin
                        wrapped = sum[39:0];
                        sum = longint'(wrapped);
                    end
                end
                m_acc = sum;
            end
        end
        e1_acc = m_acc;
        e1_ovf = m_ovf;
    endtask

    initial begin : watchdog
        #(200000 * 10);
        checks++;
        fails++;
        $display("FAIL watchdog expired: got running expected finished");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        // R10: state after reset is zero.
        step(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, "R10 reset");
        step(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, "R10 reset");

        // R1 and R3: back-to-back loads over the operand grid.
        for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
                step(1'b0, 1'b1, 1'b1, 1'b0, grid(i), grid(j), "R1 R3 load");

        // R2: accumulate the grid, with the mode bit toggling.
        step(1'b0, 1'b1, 1'b1, 1'b0, 7, -9, "R2 start");
        for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
                step(1'b0, 1'b1, 1'b0, (i + j) % 2 == 1, grid(i), grid(11 - j), "R2 accumulate");

        // R4: idle cycles with garbage on every other input.
        for (int k = 0; k < 8; k++)
            step(1'b0, 1'b0, k[0], k[1], grid(k), grid(k + 3), "R4 idle");

        // R5 and R7: saturate past the positive limit, then past the negative limit.
        step(1'b0, 1'b1, 1'b1, 1'b1, -32768, -32768, "R1 corner load");
        for (int k = 0; k < 520; k++)
            step(1'b0, 1'b1, 1'b0, 1'b1, -32768, -32768, "R5 clamp high");
        step(1'b0, 1'b1, 1'b0, 1'b1, -5, 7, "R7 sticky");
        step(1'b0, 1'b1, 1'b1, 1'b1, 32767, -32768, "R7 cleared by load");
        for (int k = 0; k < 520; k++)
            step(1'b0, 1'b1, 1'b0, 1'b1, 32767, -32768, "R5 clamp low");

        // R6: wrap mode across both limits.
        step(1'b0, 1'b1, 1'b1, 1'b0, -32768, -32768, "R6 load");
        for (int k = 0; k < 520; k++)
            step(1'b0, 1'b1, 1'b0, 1'b0, -32768, -32768, "R6 wrap high");
        step(1'b0, 1'b1, 1'b1, 1'b0, -32768, 32767, "R6 load");
        for (int k = 0; k < 520; k++)
            step(1'b0, 1'b1, 1'b0, 1'b0, -32768, 32767, "R6 wrap low");
        for (int k = 0; k < 3; k++)
            step(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, "R4 hold");

        // R10: a reset while pairs are still in flight discards them.
        step(1'b0, 1'b1, 1'b0, 1'b0, 1000, 1000, "R10 in flight");
        step(1'b1, 1'b1, 1'b0, 1'b0, 2000, 2000, "R10 reset");
        step(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, "R10 after reset");
        step(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, "R10 after reset");
        step(1'b0, 1'b1, 1'b0, 1'b0, -3, 4, "R2 after reset");
        step(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, "R3 drain");
        step(1'b0, 1'b0, 1'b0, 1'b0, 0, 0, "R3 drain");

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule